// File: doc/BRIEF.md
# SPI Serial Memory Write-Protect Controller

This block is the slave side of a four-wire serial bus that fronts a small byte-wide memory held in on-chip registers. A host selects the block with an active-low chip select and clocks command bytes in on SI. The block answers status and data reads on SO. Writes land in a page buffer and are committed by a self-timed write cycle. While that cycle runs, a busy flag is visible in the status byte.

Writes are guarded in three ways. A write enable latch must be set first. A two-bit protect field fences off none, the top quarter, the top half or all of the array. An active-low write-protect pin freezes the protect field. A reset-request input from an external low-voltage detector inhibits every write commit. That input also holds a reset output high until the input has been quiet for a settling interval.

SCK, CS, SI, the pin and the detector input are all sampled by the system clock, which must run at least eight times faster than SCK.

Top module: `spiWpMem`

## Requirements
- R1: Both idle levels of SCK work (mode 0 idles low, mode 3 idles high). SI is captured on SCK rising edges, MSB first. SO changes after SCK falling edges, MSB first. SO is 0 while csN is high.
- R2: Opcodes: 0x06 set enable latch, 0x04 clear it, 0x05 read status, 0x01 write status, 0x03 read data, 0x02 write data. The status byte is bit0 = write in progress, bit1 = enable latch, bits3:2 = protect field, with bits7:4 read as 0.
- R3: A data write or a status write is ignored unless the enable latch is set. Opcode 0x06 sets the latch and opcode 0x04 clears it.
- R4: A status write is the opcode followed by one byte, committed at the rise of csN. It copies bits3:2 of that byte into the protect field and clears the enable latch. It is ignored while wpN is low.
- R5: A data write is the opcode, a 16-bit address (MSB first) and 1 to 32 data bytes. Data bytes land at rising addresses that wrap to the start of the same 32-byte page.
- R6: A data write is discarded when csN rises with a partial byte received, or when no data byte was sent. In that case the enable latch stays set.
- R7: The protect field controls which writes are discarded. A value of 0 discards none. A value of 1 discards writes to the top quarter of the array (addresses 0xC0-0xFF at the default size). A value of 2 discards writes to the top half (0x80-0xFF). A value of 3 discards all writes.
- R8: An accepted data write sets write-in-progress at the rise of csN. After WRITE_CYCLES clock cycles, the bytes are stored and both write-in-progress and the enable latch clear.
- R9: While write-in-progress is set, only the status read is honoured. Any other command has no effect, and a data read returns 0.
- R10: While lowVdd is high, no data or status write is committed. rstOut is high while lowVdd is high, for SETTLE clock cycles after lowVdd falls, and for SETTLE cycles after rst_n is released.
- R11: A data read is the opcode and a 16-bit address. The block then returns bytes from consecutive addresses.
- R12: After reset the status byte is 0x00 and every memory byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| wpN | input | 1 | Active-low write-protect pin for the protect field |
| lowVdd | input | 1 | Reset request from the low-voltage detector |
| rstOut | output | 1 | Reset output, held through the settling interval |

## Verification
The bench tests the edges of each guard:
- A write that starts just below a page end must wrap to the page start, not spill into the next page.
- A write aborted three bits into a byte must leave memory untouched and keep the latch set.
- Writes must be discarded on both sides of the quarter and half boundaries, and the pin must freeze the protect field while data writes still pass.
- A command sent during the timed cycle must not clear the latch or return data.
- rstOut must stay high partway through the settling interval and drop only after it.

A design that got one of these wrong would corrupt a neighbouring page, lose or store aborted data, misplace a protection fence, or release reset early.

// File: rtl/spiWpPkg.sv
package spiWpPkg;
  localparam logic [7:0] OP_NOP  = 8'h00;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRIT = 8'h02;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic wrStat;
    logic bufClr;
    logic bufLd;
    logic start;
  } strobe_t;
endpackage

// File: rtl/spiWpData.sv
module spiWpData
  import spiWpPkg::*;
#(
  parameter int MEM_BYTES    = 256,
  parameter int PAGE         = 32,
  parameter int WRITE_CYCLES = 1000,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int PW = $clog2(PAGE),
  localparam int CW = $clog2(WRITE_CYCLES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  strobe_t        strb,
  input  logic [1:0]     statNew,
  input  logic [PW-1:0]  bufOff,
  input  logic [7:0]     bufData,
  input  logic [AW-PW-1:0] pageIdx,
  input  logic [AW-1:0]  rdAddr,
  output logic [7:0]     rdData,
  output logic [7:0]     status,
  output logic           busy
);
  logic [7:0] mem [MEM_BYTES];
  logic [7:0] pBuf [PAGE];
  logic [PAGE-1:0] pMask;
  logic [AW-PW-1:0] pBase;
  logic [CW-1:0] cnt;
  logic wel;
  logic [1:0] bp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
      for (int i = 0; i < PAGE; i++) pBuf[i] <= '0;
      pMask <= '0;
      pBase <= '0;
      cnt   <= '0;
      wel   <= 1'b0;
      bp    <= 2'b00;
      busy  <= 1'b0;
    end else begin
      if (strb.setWel) wel <= 1'b1;
      if (strb.clrWel) wel <= 1'b0;
      if (strb.wrStat) begin
        bp  <= statNew;
        wel <= 1'b0;
      end
      if (strb.bufClr) pMask <= '0;
      if (strb.bufLd) begin
        pBuf[bufOff]  <= bufData;
        pMask[bufOff] <= 1'b1;
      end
      if (strb.start) begin
        busy  <= 1'b1;
        cnt   <= CW'(WRITE_CYCLES - 1);
        pBase <= pageIdx;
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          wel  <= 1'b0;
          for (int i = 0; i < PAGE; i++)
            if (pMask[i]) mem[{pBase, PW'(i)}] <= pBuf[i];
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign rdData = mem[rdAddr];
  assign status = {4'b0000, bp, wel, busy};

  a_r3_start_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    strb.start |-> (wel && !busy));
  a_r8_done_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  a_r9_no_load_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(strb.bufLd || strb.wrStat || strb.setWel));
endmodule

// File: rtl/spiWpCtrl.sv
module spiWpCtrl
  import spiWpPkg::*;
#(
  parameter int MEM_BYTES = 256,
  parameter int PAGE      = 32,
  parameter int SETTLE    = 64,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int PW = $clog2(PAGE),
  localparam int SW = $clog2(SETTLE + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sck,
  input  logic           csN,
  input  logic           si,
  input  logic           wpN,
  input  logic           lowVdd,
  input  logic [7:0]     status,
  input  logic           busy,
  input  logic [7:0]     rdData,
  output logic           so,
  output logic           rstOut,
  output strobe_t        strb,
  output logic [1:0]     statNew,
  output logic [PW-1:0]  bufOff,
  output logic [7:0]     bufData,
  output logic [AW-PW-1:0] pageIdx,
  output logic [AW-1:0]  rdAddr
);
  logic [1:0] sckSy, csSy, siSy, wpSy, lowSy;
  logic sckD, csD;
  logic sckS, csS, siS, wpS, lowS;
  logic [2:0] bitCnt, byteCnt;
  logic [7:0] shReg, opcode, statByte, outSh, newByte, opNow;
  logic [15:0] addr, rdAddrFull;
  logic [SW-1:0] settleCnt;
  logic sckRise, sckFall, csRise, byteDone, outLoad, prot;
  logic [1:0] bpNow, topBits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sckSy <= '0; csSy <= '1; siSy <= '0; wpSy <= '1; lowSy <= '0;
      sckD <= 1'b0; csD <= 1'b1;
    end else begin
      sckSy <= {sckSy[0], sck};
      csSy  <= {csSy[0], csN};
      siSy  <= {siSy[0], si};
      wpSy  <= {wpSy[0], wpN};
      lowSy <= {lowSy[0], lowVdd};
      sckD  <= sckSy[1];
      csD   <= csSy[1];
    end
  end

  assign sckS = sckSy[1];
  assign csS  = csSy[1];
  assign siS  = siSy[1];
  assign wpS  = wpSy[1];
  assign lowS = lowSy[1];
  assign sckRise = sckS & ~sckD & ~csS;
  assign sckFall = ~sckS & sckD & ~csS;
  assign csRise  = csS & ~csD;
  assign byteDone = sckRise && (bitCnt == 3'd7);
  assign newByte  = {shReg[6:0], siS};
  assign opNow = (byteCnt != 3'd0) ? opcode :
                 (busy && newByte != OP_RDSR) ? OP_NOP : newByte;

  assign rdAddrFull = (byteCnt == 3'd2) ? {addr[15:8], newByte} : addr;
  assign rdAddr  = rdAddrFull[AW-1:0];
  assign bufOff  = addr[PW-1:0];
  assign bufData = newByte;
  assign pageIdx = addr[AW-1:PW];
  assign statNew = statByte[3:2];
  assign bpNow   = status[3:2];
  assign topBits = addr[AW-1:AW-2];
  assign prot = (bpNow == 2'd3) || (bpNow == 2'd2 && topBits[1]) ||
                (bpNow == 2'd1 && topBits == 2'b11);

  always_comb begin
    strb = '0;
    strb.setWel = byteDone && byteCnt == 3'd0 && opNow == OP_WREN;
    strb.clrWel = byteDone && byteCnt == 3'd0 && opNow == OP_WRDI;
    strb.bufClr = byteDone && byteCnt == 3'd0 && opNow == OP_WRIT;
    strb.bufLd  = byteDone && byteCnt >= 3'd3 && opcode == OP_WRIT;
    strb.wrStat = csRise && opcode == OP_WRSR && bitCnt == 3'd0 &&
                  byteCnt >= 3'd2 && status[1] && wpS && !lowS && !busy;
    strb.start  = csRise && opcode == OP_WRIT && bitCnt == 3'd0 &&
                  byteCnt >= 3'd4 && status[1] && !busy && !lowS && !prot;
  end

  assign outLoad = byteDone && (opNow == OP_RDSR ||
                   (opcode == OP_READ && byteCnt >= 3'd2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCnt <= '0; byteCnt <= '0; shReg <= '0; opcode <= OP_NOP;
      statByte <= '0; addr <= '0; outSh <= '0;
    end else if (csS) begin
      bitCnt <= '0; byteCnt <= '0; opcode <= OP_NOP; outSh <= '0;
    end else begin
      if (sckRise) begin
        shReg  <= newByte;
        bitCnt <= bitCnt + 1'b1;
      end
      if (byteDone) begin
        if (byteCnt != 3'd7) byteCnt <= byteCnt + 1'b1;
        case (byteCnt)
          3'd0: opcode <= opNow;
          3'd1: begin
            statByte   <= newByte;
            addr[15:8] <= newByte;
          end
          3'd2: addr <= (opcode == OP_READ) ? rdAddrFull + 16'd1
                                            : {addr[15:8], newByte};
          default: begin
            if (opcode == OP_READ) addr <= addr + 16'd1;
            else if (opcode == OP_WRIT) addr[PW-1:0] <= addr[PW-1:0] + 1'b1;
          end
        endcase
      end
      if (outLoad)
        outSh <= (opNow == OP_RDSR) ? status : rdData;
      else if (sckFall && bitCnt != 3'd0)
        outSh <= {outSh[6:0], 1'b0};
    end
  end

  assign so = outSh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settleCnt <= SW'(SETTLE);
      rstOut    <= 1'b1;
    end else begin
      if (lowS) settleCnt <= SW'(SETTLE);
      else if (settleCnt != '0) settleCnt <= settleCnt - 1'b1;
      rstOut <= lowS || (settleCnt > SW'(1));
    end
  end

  a_r10_low_forces_reset: assert property (@(posedge clk) disable iff (!rst_n)
    lowS |=> rstOut);
  a_r4_pin_freezes_protect: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!wpS) |-> $stable(status[3:2]));
  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(csS) |-> !so);
endmodule

// File: rtl/spiWpMem.sv
module spiWpMem #(
  parameter int MEM_BYTES    = 256,
  parameter int PAGE         = 32,
  parameter int WRITE_CYCLES = 1000,
  parameter int SETTLE       = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic csN,
  input  logic si,
  output logic so,
  input  logic wpN,
  input  logic lowVdd,
  output logic rstOut
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE);

  spiWpPkg::strobe_t strb;
  logic [1:0] statNew;
  logic [PW-1:0] bufOff;
  logic [7:0] bufData, rdData, status;
  logic [AW-PW-1:0] pageIdx;
  logic [AW-1:0] rdAddr;
  logic busy;

  spiWpCtrl #(.MEM_BYTES(MEM_BYTES), .PAGE(PAGE), .SETTLE(SETTLE)) uCtrl (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csN(csN), .si(si), .wpN(wpN),
    .lowVdd(lowVdd), .status(status), .busy(busy), .rdData(rdData),
    .so(so), .rstOut(rstOut), .strb(strb), .statNew(statNew),
    .bufOff(bufOff), .bufData(bufData), .pageIdx(pageIdx), .rdAddr(rdAddr));

  spiWpData #(.MEM_BYTES(MEM_BYTES), .PAGE(PAGE), .WRITE_CYCLES(WRITE_CYCLES)) uData (
    .clk(clk), .rst_n(rst_n), .strb(strb), .statNew(statNew),
    .bufOff(bufOff), .bufData(bufData), .pageIdx(pageIdx), .rdAddr(rdAddr),
    .rdData(rdData), .status(status), .busy(busy));
endmodule

// File: tb/sim_spiWpMem.sv
module sim_spiWpMem;
  localparam int WC = 1000;
  localparam int ST = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, csN = 1'b1, si = 1'b0, wpN = 1'b1, lowVdd = 1'b0;
  logic so, rstOut;
  logic mode3 = 1'b0;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  spiWpMem #(.WRITE_CYCLES(WC), .SETTLE(ST)) u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csN(csN), .si(si), .so(so),
    .wpN(wpN), .lowVdd(lowVdd), .rstOut(rstOut));

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic csLow;
    sck = mode3; waitClk(4); csN = 1'b0; waitClk(8);
  endtask

  task automatic csHigh;
    waitClk(8); csN = 1'b1; waitClk(8); sck = mode3; waitClk(4);
  endtask

  task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int b = 7; b > 7 - n; b--) begin
      if (mode3) sck = 1'b0;
      si = tx[b];
      waitClk(8);
      rx[b] = so;
      sck = 1'b1;
      waitClk(8);
      if (!mode3) sck = 1'b0;
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    xbits(tx, 8, rx);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    csLow; xbyte(op, r); csHigh;
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] r;
    csLow; xbyte(8'h05, r); xbyte(8'h00, s); csHigh;
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    csLow; xbyte(8'h01, r); xbyte(v, r); csHigh;
  endtask

  task automatic wrMem(input logic [15:0] a, input logic [7:0] d0, input int n);
    logic [7:0] r;
    csLow; xbyte(8'h02, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
    for (int i = 0; i < n; i++) xbyte(d0 + 8'(i), r);
    csHigh;
  endtask

  task automatic rdMem(input logic [15:0] a, output logic [7:0] d0, output logic [7:0] d1);
    logic [7:0] r;
    csLow; xbyte(8'h03, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
    xbyte(8'h00, d0); xbyte(8'h00, d1);
    csHigh;
  endtask

  task automatic tReset;
    logic [7:0] s, d0, d1;
    chk("R10 rstOut after reset", {7'd0, rstOut}, 8'h01);
    chk("R1 so idle", {7'd0, so}, 8'h00);
    waitClk(ST + 10);
    chk("R10 rstOut settled", {7'd0, rstOut}, 8'h00);
    rdsr(s);
    chk("R12 status reset", s, 8'h00);
    rdMem(16'h00F0, d0, d1);
    chk("R12 mem reset", d0 | d1, 8'h00);
  endtask

  task automatic tLatch;
    logic [7:0] s, d0, d1;
    cmd1(8'h06); rdsr(s);
    chk("R2 R3 latch set", s, 8'h02);
    cmd1(8'h04); rdsr(s);
    chk("R3 latch cleared", s, 8'h00);
    wrMem(16'h0010, 8'h55, 2); waitClk(WC + 50);
    rdMem(16'h0010, d0, d1);
    chk("R3 write without latch ignored", d0, 8'h00);
  endtask

  task automatic tWrite;
    logic [7:0] s, d0, d1;
    cmd1(8'h06);
    wrMem(16'h0010, 8'hA0, 4);
    rdsr(s);
    chk("R8 busy during cycle", s, 8'h03);
    cmd1(8'h04); rdsr(s);
    chk("R9 latch clear ignored while busy", s, 8'h03);
    rdMem(16'h0010, d0, d1);
    chk("R9 read ignored while busy", d0, 8'h00);
    waitClk(WC + 50);
    rdsr(s);
    chk("R8 busy and latch cleared", s, 8'h00);
    rdMem(16'h0010, d0, d1);
    chk("R11 read first", d0, 8'hA0);
    chk("R11 read incr", d1, 8'hA1);
    rdMem(16'h0012, d0, d1);
    chk("R5 third byte", d0, 8'hA2);
    chk("R5 fourth byte", d1, 8'hA3);
  endtask

  task automatic tWrap;
    logic [7:0] d0, d1;
    cmd1(8'h06);
    wrMem(16'h003E, 8'h30, 4); waitClk(WC + 50);
    rdMem(16'h003E, d0, d1);
    chk("R5 page end", d1, 8'h31);
    rdMem(16'h0020, d0, d1);
    chk("R5 wrap to page start", d0, 8'h32);
    chk("R5 wrap second", d1, 8'h33);
    rdMem(16'h0040, d0, d1);
    chk("R5 next page untouched", d0, 8'h00);
  endtask

  task automatic tAbort;
    logic [7:0] r, s, d0, d1;
    cmd1(8'h06);
    csLow; xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h50, r);
    xbyte(8'h99, r); xbits(8'hFF, 3, r); csHigh;
    rdsr(s);
    chk("R6 partial byte keeps latch, not busy", s, 8'h02);
    wrMem(16'h0050, 8'h00, 0);
    rdsr(s);
    chk("R6 no data byte not busy", s, 8'h02);
    rdMem(16'h0050, d0, d1);
    chk("R6 aborted data not stored", d0, 8'h00);
    cmd1(8'h04);
  endtask

  task automatic tMode3;
    logic [7:0] s, d0, d1;
    mode3 = 1'b1; sck = 1'b1; waitClk(8);
    cmd1(8'h06);
    rdsr(s);
    chk("R1 mode3 status", s, 8'h02);
    wrMem(16'h0070, 8'hC5, 2); waitClk(WC + 50);
    rdMem(16'h0070, d0, d1);
    chk("R1 mode3 data", d0, 8'hC5);
    chk("R1 mode3 data2", d1, 8'hC6);
    mode3 = 1'b0; sck = 1'b0; waitClk(8);
  endtask

  task automatic tProtect;
    logic [7:0] s, d0, d1;
    cmd1(8'h06); wrsr(8'h04); rdsr(s);
    chk("R4 protect quarter set, latch cleared", s, 8'h04);
    cmd1(8'h06); wrMem(16'h00C0, 8'h11, 1);
    rdsr(s);
    chk("R7 quarter blocks top, latch kept", s, 8'h06);
    wrMem(16'h00A0, 8'h22, 1); waitClk(WC + 50);
    rdMem(16'h00A0, d0, d1);
    chk("R7 below quarter allowed", d0, 8'h22);
    rdMem(16'h00C0, d0, d1);
    chk("R7 top quarter unchanged", d0, 8'h00);
    cmd1(8'h06); wrsr(8'h08);
    cmd1(8'h06); wrMem(16'h0080, 8'h33, 1); waitClk(WC + 50);
    rdMem(16'h0080, d0, d1);
    chk("R7 half blocks 0x80", d0, 8'h00);
    wpN = 1'b0; waitClk(4);
    wrsr(8'h00); rdsr(s);
    chk("R4 pin freezes protect", s, 8'h0A);
    wrMem(16'h0000, 8'h44, 1); waitClk(WC + 50);
    rdMem(16'h0000, d0, d1);
    chk("R4 data write passes with pin", d0, 8'h44);
    wpN = 1'b1; waitClk(4);
    cmd1(8'h06); wrsr(8'h0C);
    cmd1(8'h06); wrMem(16'h0001, 8'h55, 1); waitClk(WC + 50);
    rdMem(16'h0001, d0, d1);
    chk("R7 all protected", d0, 8'h00);
    wrsr(8'h00); rdsr(s);
    chk("R4 clear protect", s, 8'h00);
  endtask

  task automatic tLowV;
    logic [7:0] d0, d1;
    lowVdd = 1'b1; waitClk(6);
    chk("R10 rstOut with low supply", {7'd0, rstOut}, 8'h01);
    cmd1(8'h06);
    wrMem(16'h0060, 8'h77, 1); waitClk(WC + 50);
    lowVdd = 1'b0; waitClk(20);
    chk("R10 rstOut held in settle", {7'd0, rstOut}, 8'h01);
    waitClk(ST + 20);
    chk("R10 rstOut released", {7'd0, rstOut}, 8'h00);
    rdMem(16'h0060, d0, d1);
    chk("R10 write inhibited", d0, 8'h00);
  endtask

  initial begin
    waitClk(5);
    rst_n = 1'b1;
    waitClk(2);
    tReset;
    tLatch;
    tWrite;
    tWrap;
    tAbort;
    tMode3;
    tProtect;
    tLowV;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule